// File: doc/BRIEF.md
# Aliased Sub-Register File

This block is a general-purpose integer register file with sixteen 64-bit entries, one write port and two read ports. Each access names a register, an operand size (byte, word, doubleword or quadword) and, for byte accesses, whether the upper byte of the low word is meant. A write merges its data into the stored entry. The merge rule depends on the size. A doubleword write clears the upper 32 bits. Word and byte writes leave every bit outside their slice alone.

Registers 0 to 3 are the accumulator, count, data and base registers. Only these four have an addressable high byte at bits 15:8. Registers 4 to 7 are the stack pointer, frame pointer, source index and destination index, and registers 8 to 15 follow them. A high-byte request aimed at registers 4 to 15 is rejected. Each read port returns the requested slice zero-extended to 64 bits. A write and a read to the same register in the same cycle return the merged new value.

Top module: `alias_regfile`

## Requirements
- R1: While reset is active and after it is released, every register reads as zero until it is written.
- R2: A quadword write (size code 2'b11) replaces all 64 bits of the entry.
- R3: A doubleword write (size code 2'b10) stores write data bits 31:0 in bits 31:0 and forces bits 63:32 to zero. The value is never sign-extended.
- R4: A word write (size code 2'b01) stores write data bits 15:0 in bits 15:0 and keeps bits 63:16.
- R5: A byte write (size code 2'b00) with the high select low stores write data bits 7:0 in bits 7:0 of any register and keeps bits 63:8.
- R6: A byte write with the high select set, to registers 0 to 3, stores write data bits 7:0 in bits 15:8 and keeps all other bits.
- R7: A high-byte request on registers 4 to 15 raises the illegal flag of that port. If it is a write, the entry is left unchanged. If it is a read, the data output is zero. The high select is ignored for sizes other than byte.
- R8: A read returns the slice given by its size code, zero-extended to 64 bits. A high-byte read returns bits 15:8 on output bits 7:0.
- R9: A read of the register being written in the same cycle returns the merged value that the write will store.
- R10: The two read ports are independent and may address different registers with different sizes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all entries |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register written |
| wr_size | input | 2 | Write size: 00 byte, 01 word, 10 dword, 11 qword |
| wr_hi | input | 1 | Byte write targets bits 15:8 |
| wr_data | input | 64 | Write data, low-aligned |
| wr_illegal | output | 1 | Write rejected as an illegal high-byte request |
| rd0_idx | input | 4 | Register read on port 0 |
| rd0_size | input | 2 | Read size on port 0 |
| rd0_hi | input | 1 | High-byte read on port 0 |
| rd0_data | output | 64 | Zero-extended read data, port 0 |
| rd0_illegal | output | 1 | Illegal high-byte read on port 0 |
| rd1_idx | input | 4 | Register read on port 1 |
| rd1_size | input | 2 | Read size on port 1 |
| rd1_hi | input | 1 | High-byte read on port 1 |
| rd1_data | output | 64 | Zero-extended read data, port 1 |
| rd1_illegal | output | 1 | Illegal high-byte read on port 1 |

## Verification
The assertions assume that the control inputs are known whenever reset is released. They also assume that a write's effect is judged one cycle later at the stored entry, with no second write to the same register in between. The bench meets both conditions. It drives every input from a defined value at time zero and issues at most one write per cycle. Each write is followed by a read-back cycle with the write enable low, so the merged results are observed on their own. Only the dedicated same-cycle test has a write and a read to the same register together.

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int NREGS   = 16,
  parameter int HI_REGS = 4,
  localparam int DW     = 64,
  localparam int IW     = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_size,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  output logic          wr_illegal,
  input  logic [IW-1:0] rd0_idx,
  input  logic [1:0]    rd0_size,
  input  logic          rd0_hi,
  output logic [DW-1:0] rd0_data,
  output logic          rd0_illegal,
  input  logic [IW-1:0] rd1_idx,
  input  logic [1:0]    rd1_size,
  input  logic          rd1_hi,
  output logic [DW-1:0] rd1_data,
  output logic          rd1_illegal
);

  localparam logic [1:0] SZ_B = 2'b00;
  localparam logic [1:0] SZ_W = 2'b01;
  localparam logic [1:0] SZ_D = 2'b10;

  logic [DW-1:0] regs [NREGS];
  logic          wr_ok;
  logic [DW-1:0] wr_merged;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [1:0] sz, input logic hi);
    case (sz)
      SZ_B:    merge = hi ? {old[63:16], d[7:0], old[7:0]} : {old[63:8], d[7:0]};
      SZ_W:    merge = {old[63:16], d[15:0]};
      SZ_D:    merge = {32'd0, d[31:0]};
      default: merge = d;
    endcase
  endfunction

  function automatic logic [DW-1:0] slice(input logic [DW-1:0] v, input logic [1:0] sz,
                                          input logic hi);
    case (sz)
      SZ_B:    slice = hi ? {56'd0, v[15:8]} : {56'd0, v[7:0]};
      SZ_W:    slice = {48'd0, v[15:0]};
      SZ_D:    slice = {32'd0, v[31:0]};
      default: slice = v;
    endcase
  endfunction

  function automatic logic hi_bad(input logic [IW-1:0] idx, input logic [1:0] sz,
                                  input logic hi);
    hi_bad = hi && (sz == SZ_B) && (int'(idx) >= HI_REGS);
  endfunction

  assign wr_illegal = wr_en && hi_bad(wr_idx, wr_size, wr_hi);
  assign wr_ok      = wr_en && !wr_illegal;
  assign wr_merged  = merge(regs[wr_idx], wr_data, wr_size, wr_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      regs[wr_idx] <= wr_merged;
    end
  end

  logic [DW-1:0] rd0_full, rd1_full;
  assign rd0_full    = (wr_ok && wr_idx == rd0_idx) ? wr_merged : regs[rd0_idx];
  assign rd1_full    = (wr_ok && wr_idx == rd1_idx) ? wr_merged : regs[rd1_idx];
  assign rd0_illegal = hi_bad(rd0_idx, rd0_size, rd0_hi);
  assign rd1_illegal = hi_bad(rd1_idx, rd1_size, rd1_hi);
  assign rd0_data    = rd0_illegal ? '0 : slice(rd0_full, rd0_size, rd0_hi);
  assign rd1_data    = rd1_illegal ? '0 : slice(rd1_full, rd1_size, rd1_hi);

  // R3
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == SZ_D) |=> regs[$past(wr_idx)][63:32] == 32'd0);

  // R4
  word_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == SZ_W) |=> regs[$past(wr_idx)][63:16] == $past(regs[wr_idx][63:16]));

  // R6
  hi_byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_size == SZ_B && wr_hi) |=>
      (regs[$past(wr_idx)][7:0] == $past(regs[wr_idx][7:0])) &&
      (regs[$past(wr_idx)][15:8] == $past(wr_data[7:0])));

  // R7
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |=> regs[$past(wr_idx)] == $past(regs[wr_idx]));

  // R7
  illegal_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_illegal |-> rd0_data == '0) and (rd1_illegal |-> rd1_data == '0));

  // R9
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_idx == rd0_idx && rd0_size == 2'b11) |=> regs[$past(wr_idx)] == $past(rd0_data));

endmodule

// File: tb/alias_regfile_tb_top.sv
module alias_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [1:0]  wr_size = '0;
  logic        wr_hi = 1'b0;
  logic [63:0] wr_data = '0;
  logic        wr_illegal;
  logic [3:0]  rd0_idx = '0, rd1_idx = '0;
  logic [1:0]  rd0_size = 2'b11, rd1_size = 2'b11;
  logic        rd0_hi = 1'b0, rd1_hi = 1'b0;
  logic [63:0] rd0_data, rd1_data;
  logic        rd0_illegal, rd1_illegal;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alias_regfile dut_i (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  idx;
    logic [1:0]  wsz;
    logic        whi;
    logic [63:0] wd;
    logic [1:0]  rsz;
    logic        rhi;
    logic [63:0] full;
    logic [63:0] slc;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{4'd2,  4'd0,  2'b11, 1'b0, 64'h1122334455667788, 2'b10, 1'b0, 64'h1122334455667788, 64'h55667788},         // R2
    '{4'd4,  4'd0,  2'b01, 1'b0, 64'hFFFFFFFFFFFFAAAA, 2'b01, 1'b0, 64'h112233445566AAAA, 64'hAAAA},             // R4
    '{4'd6,  4'd0,  2'b00, 1'b1, 64'hFFFFFFFFFFFFFF5A, 2'b00, 1'b1, 64'h1122334455665AAA, 64'h5A},               // R6
    '{4'd5,  4'd0,  2'b00, 1'b0, 64'hFFFFFFFFFFFFFF3C, 2'b00, 1'b0, 64'h1122334455665A3C, 64'h3C},               // R5
    '{4'd3,  4'd0,  2'b10, 1'b0, 64'hFFFFFFFF80000001, 2'b11, 1'b0, 64'h0000000080000001, 64'h0000000080000001}, // R3
    '{4'd2,  4'd9,  2'b11, 1'b0, 64'hDEADBEEFCAFEF00D, 2'b00, 1'b0, 64'hDEADBEEFCAFEF00D, 64'h0D},               // R2
    '{4'd3,  4'd9,  2'b10, 1'b1, 64'hFFFFFFFF12345678, 2'b01, 1'b0, 64'h0000000012345678, 64'h5678},             // R3 (hi ignored)
    '{4'd8,  4'd15, 2'b11, 1'b0, 64'h0123456789ABCDEF, 2'b00, 1'b0, 64'h0123456789ABCDEF, 64'hEF},               // R8
    '{4'd5,  4'd15, 2'b00, 1'b0, 64'h0000000000000000, 2'b10, 1'b0, 64'h0123456789ABCD00, 64'h89ABCD00},         // R5
    '{4'd8,  4'd3,  2'b11, 1'b0, 64'hFFFFFFFFFFFFFFFF, 2'b00, 1'b1, 64'hFFFFFFFFFFFFFFFF, 64'hFF},               // R8
    '{4'd4,  4'd3,  2'b01, 1'b1, 64'h0000000000000000, 2'b11, 1'b0, 64'hFFFFFFFFFFFF0000, 64'hFFFFFFFFFFFF0000}, // R4 (hi ignored)
    '{4'd6,  4'd3,  2'b00, 1'b1, 64'h0000000000000077, 2'b00, 1'b1, 64'hFFFFFFFFFFFF7700, 64'h77}                // R6
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    #5;
    chk("R1 in reset", rd0_data, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rd0_idx = i[3:0]; rd0_size = 2'b11;
      rd1_idx = 4'(15 - i); rd1_size = 2'b11;
      #2;
      chk("R1 port0", rd0_data, 64'd0);
      chk("R1 port1", rd1_data, 64'd0);
    end

    foreach (TBL[k]) begin
      @(negedge clk);
      wr_en = 1; wr_idx = TBL[k].idx; wr_size = TBL[k].wsz; wr_hi = TBL[k].whi; wr_data = TBL[k].wd;
      rd0_idx = 4'd14; rd1_idx = 4'd13;
      @(negedge clk);
      wr_en = 0;
      rd0_idx = TBL[k].idx; rd0_size = 2'b11; rd0_hi = 0;
      rd1_idx = TBL[k].idx; rd1_size = TBL[k].rsz; rd1_hi = TBL[k].rhi;
      #2;
      chk($sformatf("R%0d vec%0d full", TBL[k].req, k), rd0_data, TBL[k].full);
      chk($sformatf("R%0d/R8 vec%0d slice", TBL[k].req, k), rd1_data, TBL[k].slc);
    end

    // R10: both ports on different registers and sizes together
    @(negedge clk);
    rd0_idx = 4'd9;  rd0_size = 2'b11; rd0_hi = 0;
    rd1_idx = 4'd15; rd1_size = 2'b01; rd1_hi = 0;
    #2;
    chk("R10 port0", rd0_data, 64'h0000000012345678);
    chk("R10 port1", rd1_data, 64'hCD00);

    // R7: illegal high-byte write to register 5
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd5; wr_size = 2'b11; wr_hi = 0; wr_data = 64'h5555666677778888;
    @(negedge clk);
    wr_idx = 4'd5; wr_size = 2'b00; wr_hi = 1; wr_data = 64'h99;
    #2;
    chk("R7 wr_illegal", {63'd0, wr_illegal}, 64'd1);
    @(negedge clk);
    wr_en = 0; wr_hi = 0;
    rd0_idx = 4'd5; rd0_size = 2'b11; rd0_hi = 0;
    rd1_idx = 4'd5; rd1_size = 2'b00; rd1_hi = 1;
    #2;
    chk("R7 no write", rd0_data, 64'h5555666677778888);
    chk("R7 rd data zero", rd1_data, 64'd0);
    chk("R7 rd_illegal", {63'd0, rd1_illegal}, 64'd1);
    chk("R7 legal flag low", {63'd0, rd0_illegal}, 64'd0);

    // R9: same-cycle bypass of merged value
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd0; wr_size = 2'b01; wr_hi = 0; wr_data = 64'h1234;
    rd0_idx = 4'd0; rd0_size = 2'b11; rd0_hi = 0;
    rd1_idx = 4'd0; rd1_size = 2'b00; rd1_hi = 1;
    #2;
    chk("R9 bypass full", rd0_data, 64'h0000000080001234);
    chk("R9 bypass hi", rd1_data, 64'h12);
    @(negedge clk);
    wr_en = 0;
    #2;
    chk("R9 stored", rd0_data, 64'h0000000080001234);

    @(negedge clk);
    finish_run();
  end
endmodule